// File: doc/BRIEF.md
# Line Alarm Interrupt Collector

This block sits beside a T1/E1 receive framer and gathers the alarm and error events that the receive datapath raises, such as a bipolar-violation indication and a loss-of-signal indication. Each event input is compared with its value in the previous clock. Any transition, rising or falling, sets a sticky status bit. That bit stays set until the host services it, so a short alarm cannot be missed between two polls.

A small register bus gives the host four registers. A control register selects the clearing policy: status bits are cleared either by reading them, or by writing ones to them. A block enable register gates the whole group. The status register is readable. A per-source enable register decides which status bits may reach the interrupt. The single output `irq_o` is a level. It is high while the block enable is set and at least one status bit is set whose own enable is also set.

Top module: `alm_irq_ctrl`

## Requirements
- R1: A transition in either direction on bit i of `evt_i`, compared with its value in the previous clock, sets status bit i at the next clock edge. A bit whose input has not changed is not set.
- R2: A set status bit holds until a clearing access from the host. It does not clear when the event input goes quiet or returns to its earlier value.
- R3: The control register at offset 0 uses bit 0 to select read-to-clear mode. When that bit is one, a read of the status register at offset 2 returns the current bits, and the same clock edge clears exactly those bits. The interrupt drops if nothing else holds it.
- R4: When control bit 0 is zero, a write to offset 2 clears each status bit whose write-data bit is one and leaves the bits written as zero. In this mode, reads of the status register change nothing.
- R5: In read-to-clear mode, a write to the status register leaves every status bit unchanged.
- R6: An event transition that arrives in the same cycle as a clearing read or clearing write leaves its status bit set.
- R7: Bit 0 of the block enable register at offset 1 gates the interrupt. When it is zero, `irq_o` is low whatever the status holds, and status bits are still recorded.
- R8: The per-source enable register at offset 3 has one bit per source: bit 0 is bipolar violation and bit 1 is loss of signal. `irq_o` is high only if the block enable is set and some status bit is set together with its enable. A disabled source still records its status.
- R9: After reset, all four registers read zero and `irq_o` is low. The control, block enable and per-source enable registers read back the values written to them.
- R10: `irq_o` is a level. It stays high on every cycle for as long as its enabling condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_SRC | Alarm event levels from the receive datapath (bit 0 bipolar violation, bit 1 loss of signal) |
| bus_sel_i | input | 1 | Register access strobe, one cycle per access |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 2 | Register offset |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data for the addressed register, combinational |
| irq_o | output | 1 | Level interrupt toward the host |

## Verification
Several properties are checked on every cycle. A transition always lands in status, and an event wins over a same-cycle clear. A set bit never disappears unless a clear targeted it. A write in read-to-clear mode never removes a bit. `irq_o` is never high while the block enable is off or while no enabled source has status set. Some behaviour can only be shown by the bench's scenarios. These include the exact value a read returns before clearing, the choice between the two clearing policies, the read-back of the enable registers, and the interrupt staying high as a level over many cycles and then falling when the host services it.

// File: rtl/alm_pkg.sv
package alm_pkg;

    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        REG_CTRL  = 2'd0,
        REG_BLKEN = 2'd1,
        REG_STAT  = 2'd2,
        REG_SRCEN = 2'd3
    } alm_reg_e;

    localparam int unsigned CTRL_RTC_BIT  = 0;
    localparam int unsigned BLKEN_ALL_BIT = 0;

    typedef struct packed {
        logic rd_to_clr;
        logic blk_en;
    } alm_cfg_t;

endpackage

// File: rtl/alm_change_det.sv
module alm_change_det #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [NUM_SRC-1:0] chg_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] prev;
    } det_state_t;

    det_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.prev = evt_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chg_o = evt_i ^ state_q.prev;

endmodule

// File: rtl/alm_status_bank.sv
module alm_status_bank #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] chg_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] stat_o
);

    typedef struct packed {
        logic [NUM_SRC-1:0] stat;
    } bank_state_t;

    bank_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (chg_i[i]) begin
                state_d.stat[i] = 1'b1;
            end else if (clr_i[i]) begin
                state_d.stat[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign stat_o = state_q.stat;

    // R1 R6
    change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg_i != '0) |=> ((stat_o & $past(chg_i)) == $past(chg_i)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(stat_o) & ~$past(clr_i) & ~stat_o) == '0));

endmodule

// File: rtl/alm_irq_gate.sv
module alm_irq_gate #(
    parameter int unsigned NUM_SRC = 8
) (
    input  logic               blk_en_i,
    input  logic [NUM_SRC-1:0] stat_i,
    input  logic [NUM_SRC-1:0] src_en_i,
    output logic               irq_o
);

    logic [NUM_SRC-1:0] armed;

    always_comb begin
        armed = stat_i & src_en_i;
        irq_o = blk_en_i && (armed != '0);
    end

endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
    import alm_pkg::*;
#(
    parameter int unsigned NUM_SRC = 8,
    parameter int unsigned DATA_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  evt_i,
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [1:0]          bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    output logic                irq_o
);

    localparam int unsigned SRC_HI = NUM_SRC - 1;

    typedef struct packed {
        alm_cfg_t            cfg;
        logic [NUM_SRC-1:0]  src_en;
    } regs_t;

    regs_t regs_d, regs_q;

    logic               wr_acc, rd_acc;
    logic               stat_wr, stat_rd;
    logic [NUM_SRC-1:0] chg, clr, stat;

    alm_change_det #(.NUM_SRC(NUM_SRC)) u_det (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (evt_i),
        .chg_o (chg)
    );

    alm_status_bank #(.NUM_SRC(NUM_SRC)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .chg_i  (chg),
        .clr_i  (clr),
        .stat_o (stat)
    );

    alm_irq_gate #(.NUM_SRC(NUM_SRC)) u_gate (
        .blk_en_i (regs_q.cfg.blk_en),
        .stat_i   (stat),
        .src_en_i (regs_q.src_en),
        .irq_o    (irq_o)
    );

    always_comb begin
        wr_acc  = bus_sel_i && bus_wr_i;
        rd_acc  = bus_sel_i && !bus_wr_i;
        stat_wr = wr_acc && (alm_reg_e'(bus_addr_i) == REG_STAT);
        stat_rd = rd_acc && (alm_reg_e'(bus_addr_i) == REG_STAT);
    end

    always_comb begin
        clr = '0;
        if (regs_q.cfg.rd_to_clr) begin
            if (stat_rd) clr = stat;
        end else begin
            if (stat_wr) clr = bus_wdata_i[SRC_HI:0];
        end
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_acc) begin
            unique case (alm_reg_e'(bus_addr_i))
                REG_CTRL:  regs_d.cfg.rd_to_clr = bus_wdata_i[CTRL_RTC_BIT];
                REG_BLKEN: regs_d.cfg.blk_en    = bus_wdata_i[BLKEN_ALL_BIT];
                REG_SRCEN: regs_d.src_en        = bus_wdata_i[SRC_HI:0];
                default:   regs_d               = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        unique case (alm_reg_e'(bus_addr_i))
            REG_CTRL:  bus_rdata_o[CTRL_RTC_BIT]  = regs_q.cfg.rd_to_clr;
            REG_BLKEN: bus_rdata_o[BLKEN_ALL_BIT] = regs_q.cfg.blk_en;
            REG_STAT:  bus_rdata_o[SRC_HI:0]      = stat;
            REG_SRCEN: bus_rdata_o[SRC_HI:0]      = regs_q.src_en;
            default:   bus_rdata_o                = '0;
        endcase
    end

    // R7
    blk_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q.cfg.blk_en |-> !irq_o);

    // R8
    src_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat & regs_q.src_en) == '0) |-> !irq_o);

    // R5
    rtc_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.cfg.rd_to_clr && stat_wr && !stat_rd) |=> (($past(stat) & ~stat) == '0));

    // R3
    rtc_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.cfg.rd_to_clr && stat_rd) |=> ((stat & $past(stat) & ~$past(chg)) == '0));

    // R4
    w1c_read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.cfg.rd_to_clr && stat_rd) |=> (($past(stat) & ~stat) == '0));

endmodule

// File: tb/alm_irq_ctrl_test.sv
module alm_irq_ctrl_test;

    localparam int unsigned NS = 8;
    localparam int unsigned DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] evt = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [1:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    alm_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .bus_sel_i   (sel),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [DW-1:0] d);
        @(negedge clk);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        sel = 1'b0;
    endtask

    task automatic set_evt(input logic [NS-1:0] v);
        @(negedge clk);
        evt = v;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], d);
            chk("R9 reset register", d, 0);
        end
        chk("R9 reset irq", irq, 0);
    endtask

    task automatic t_sticky();
        logic [DW-1:0] d;
        set_evt(8'h01);
        bus_read(2'd2, d);
        chk("R1 rise sets status", d, 8'h01);
        set_evt(8'h00);
        repeat (3) @(negedge clk);
        bus_read(2'd2, d);
        chk("R2 status holds", d, 8'h01);
        bus_read(2'd2, d);
        chk("R4 read does not clear", d, 8'h01);
        bus_write(2'd2, 8'h00);
        bus_read(2'd2, d);
        chk("R4 zero write keeps", d, 8'h01);
        bus_write(2'd2, 8'h01);
        bus_read(2'd2, d);
        chk("R4 one write clears", d, 8'h00);
        chk("R8 no irq when disabled", irq, 0);
    endtask

    task automatic t_enables();
        logic [DW-1:0] d;
        bus_write(2'd3, 8'h02);
        bus_write(2'd1, 8'h01);
        bus_read(2'd3, d);
        chk("R9 source enable readback", d, 8'h02);
        bus_read(2'd1, d);
        chk("R9 block enable readback", d, 8'h01);
        set_evt(8'h01);
        chk("R8 disabled source no irq", irq, 0);
        set_evt(8'h03);
        chk("R8 enabled source irq", irq, 1);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R10 irq level held", irq, 1);
        end
        bus_write(2'd1, 8'h00);
        chk("R7 block disable irq low", irq, 0);
        bus_read(2'd2, d);
        chk("R7 status kept while gated", d, 8'h03);
        bus_write(2'd1, 8'h01);
        chk("R7 block enable irq back", irq, 1);
        bus_write(2'd2, 8'h02);
        chk("R8 irq drops after clear", irq, 0);
        bus_read(2'd2, d);
        chk("R4 selective clear", d, 8'h01);
    endtask

    task automatic t_rtc();
        logic [DW-1:0] d;
        bus_write(2'd0, 8'h01);
        bus_read(2'd0, d);
        chk("R9 control readback", d, 8'h01);
        set_evt(8'h01);
        chk("R1 fall sets irq", irq, 1);
        bus_write(2'd2, 8'hFF);
        chk("R5 write ignored irq", irq, 1);
        bus_read(2'd2, d);
        chk("R3 read returns bits", d, 8'h03);
        chk("R3 irq cleared by read", irq, 0);
        bus_read(2'd2, d);
        chk("R3 status cleared", d, 8'h00);
    endtask

    task automatic t_priority();
        logic [DW-1:0] d;
        @(negedge clk);
        evt = 8'h03;
        sel = 1'b1; wr = 1'b0; addr = 2'd2;
        @(negedge clk);
        sel = 1'b0;
        bus_read(2'd2, d);
        chk("R6 event beats read clear", d, 8'h02);
        bus_write(2'd0, 8'h00);
        bus_read(2'd2, d);
        chk("R3 status empty", d, 8'h00);
        @(negedge clk);
        evt = 8'h01;
        sel = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 8'hFF;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0;
        bus_read(2'd2, d);
        chk("R6 event beats write clear", d, 8'h02);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sticky();
        t_enables();
        t_rtc();
        t_priority();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule